// File: doc/BRIEF.md
# Interleaved Three-Channel Timer Register Bank

This block is the register front end for three identical 16-bit timer channels. A simple bus of valid, write, address and data signals reaches all three channels through one address map. Each kind of register is a group of three consecutive 32-bit words, one word per channel. The word index is the byte address shifted right by two. The channel is that index modulo three, and the group is that index divided by three. Each channel core holds its settings, a running count, six status flags and an interrupt output.

Reads return data one cycle after they are accepted. Reading a channel's status word returns its flags and clears them in the same access. Writing counter control with the count-reset bit set zeroes that channel's count. The three interrupt lines are kept separate.

Top module: `tri_timer_regbank`

## Requirements
- R1: After reset, counter control reads 0x21, so the channel is halted. Every other register, every count and every status flag reads zero, and all three interrupt lines are low.
- R2: Address bits 1:0 are ignored. With word index i = addr>>2, the channel is i mod 3 and the group is i / 3. The groups in order are: clock control, counter control, count, interval, match 1, match 2, match 3, status, interrupt enable, event control, event value. An access to one channel leaves the other two untouched.
- R3: Clock control and interrupt enable keep write bits 5:0. Event control keeps bits 2:0. Interval keeps bits 15:0. Bits that are not kept read as zero.
- R4: Counter control stores bits 5:0 except bit 4, which always reads zero. A write with bit 4 set makes the count zero at that clock edge, and this overrides counting.
- R5: While counter-control bit 0 is clear, the count advances by one each cycle. With bit 1 set and count equal to interval, the count goes to 0 and status bit 0 is set. Otherwise, a count of 0xFFFF goes to 0 and status bit 4 is set. A count read returns the value in the accepting cycle, zero-extended.
- R6: Match registers keep bits 15:0. While the channel runs and counter-control bit 3 is set, a count equal to match k (k = 1..3) sets status bit k.
- R7: A status read returns the flags and clears them. A flag raised in the same cycle as the read survives. Writes to status have no effect.
- R8: Word indices of 33 and above read zero and ignore writes. The event-value group always reads zero.
- R9: Interrupt line c is high exactly when channel c has a status flag whose interrupt-enable bit is set.
- R10: An accepted read raises rd_valid in the next cycle with its data. Otherwise rd_valid is low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, accepted in the cycle it is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
The hardest case to reach is a status read in the same cycle that the counter raises a flag. The stimulus reaches it by running a channel with a three-cycle interval while reading its status every second cycle, so the two events keep drifting past each other. The free-running overflow flag needs 65536 counted cycles, so one channel is left running that long. A behavioural model compares every read and every interrupt line on every clock. Channel isolation is covered by giving the three channels distinct values and reading them back.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int NUM_GROUPS = 11;
  localparam int FLAG_W     = 6;

  typedef enum logic [3:0] {
    G_CLK   = 4'd0,
    G_CTRL  = 4'd1,
    G_COUNT = 4'd2,
    G_INTV  = 4'd3,
    G_M1    = 4'd4,
    G_M2    = 4'd5,
    G_M3    = 4'd6,
    G_STAT  = 4'd7,
    G_IEN   = 4'd8,
    G_EVC   = 4'd9,
    G_EVV   = 4'd10,
    G_NONE  = 4'd15
  } grp_e;

  // counter-control bit positions
  localparam int C_HALT  = 0;
  localparam int C_INTV  = 1;
  localparam int C_MATCH = 3;
  localparam int C_CRST  = 4;
  // status bit positions
  localparam int S_INTV  = 0;
  localparam int S_OVF   = 4;
endpackage

// File: rtl/tt_addr_decode.sv
module tt_addr_decode
  import tt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [CH_W-1:0]   chan
);
  logic [ADDR_W-3:0] word_idx;
  logic              unused_lsb;

  assign word_idx   = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    int unsigned iw;
    iw   = 32'(word_idx);
    chan = CH_W'(iw % NUM_CH);
    if ((iw / NUM_CH) < NUM_GROUPS) grp = grp_e'(4'(iw / NUM_CH));
    else                             grp = G_NONE;
  end
endmodule

// File: rtl/tt_chan_core.sv
module tt_chan_core
  import tt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int NUM_M  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_stat,
  input  grp_e              grp,
  input  logic [CNT_W-1:0]  wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              irq
);
  logic [5:0]        clk_q, ctrl_q, ien_q;
  logic [2:0]        evc_q;
  logic [CNT_W-1:0]  intv_q, cnt_q, cnt_d;
  logic [FLAG_W-1:0] stat_q, stat_d, ev;
  logic [CNT_W-1:0]  match_q [NUM_M];
  logic [NUM_M-1:0]  m_hit;
  logic              run, hit_intv, hit_ovf, cnt_rst, cnt_en, stat_en;
  logic              clk_en, ctrl_en, intv_en, ien_en, evc_en;

  assign run      = ~ctrl_q[C_HALT];
  assign hit_intv = run & ctrl_q[C_INTV] & (cnt_q == intv_q);
  assign hit_ovf  = run & ~hit_intv & (&cnt_q);
  assign clk_en   = wr_en & (grp == G_CLK);
  assign ctrl_en  = wr_en & (grp == G_CTRL);
  assign intv_en  = wr_en & (grp == G_INTV);
  assign ien_en   = wr_en & (grp == G_IEN);
  assign evc_en   = wr_en & (grp == G_EVC);
  assign cnt_rst  = ctrl_en & wdata[C_CRST];

  generate
    for (genvar k = 0; k < NUM_M; k++) begin : g_match
      logic m_en;
      assign m_en     = wr_en & (grp == grp_e'(4'(int'(G_M1) + k)));
      assign m_hit[k] = run & ctrl_q[C_MATCH] & (cnt_q == match_q[k]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    match_q[k] <= '0;
        else if (m_en) match_q[k] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    ev            = '0;
    ev[S_INTV]    = hit_intv;
    ev[S_OVF]     = hit_ovf;
    ev[NUM_M:1]   = m_hit;
    stat_d        = (stat_q & ~{FLAG_W{clr_stat}}) | ev;
    stat_en       = clr_stat | (|ev);
    cnt_en        = cnt_rst | run;
    if (cnt_rst || hit_intv || hit_ovf) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      ctrl_q <= 6'h21;
      intv_q <= '0;
      ien_q  <= '0;
      evc_q  <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      if (clk_en)  clk_q  <= wdata[5:0];
      if (ctrl_en) ctrl_q <= wdata[5:0] & ~6'(1 << C_CRST);
      if (intv_en) intv_q <= wdata;
      if (ien_en)  ien_q  <= wdata[5:0];
      if (evc_en)  evc_q  <= wdata[2:0];
      if (cnt_en)  cnt_q  <= cnt_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  always_comb begin
    case (grp)
      G_CLK:   rd_word = DATA_W'(clk_q);
      G_CTRL:  rd_word = DATA_W'(ctrl_q);
      G_COUNT: rd_word = DATA_W'(cnt_q);
      G_INTV:  rd_word = DATA_W'(intv_q);
      G_M1:    rd_word = DATA_W'(match_q[0]);
      G_M2:    rd_word = DATA_W'(match_q[1]);
      G_M3:    rd_word = DATA_W'(match_q[2]);
      G_STAT:  rd_word = DATA_W'(stat_q);
      G_IEN:   rd_word = DATA_W'(ien_q);
      G_EVC:   rd_word = DATA_W'(evc_q);
      default: rd_word = '0;
    endcase
  end

  assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/tt_read_mux.sv
module tt_read_mux #(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_acc,
  input  logic [CH_W-1:0]                chan,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  words,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data
);
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = '0;
    if (rd_acc && (32'(chan) < NUM_CH)) data_d = words[chan];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_acc;
      rd_data  <= data_d;
    end
  end
endmodule

// File: rtl/tri_timer_regbank.sv
module tri_timer_regbank
  import tt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] irq
);
  logic [1:0]                     rst_pipe;
  logic                           rst_core_n;
  grp_e                           grp;
  logic [CH_W-1:0]                chan;
  logic                           wr_acc, rd_acc;
  logic [NUM_CH-1:0][DATA_W-1:0]  words;
  logic                           unused_wdata_hi;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
  assign wr_acc = bus_valid & bus_write & (grp != G_NONE);
  assign rd_acc = bus_valid & ~bus_write;

  tt_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) i_dec (
    .addr (bus_addr),
    .grp  (grp),
    .chan (chan)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = (chan == CH_W'(c));
      tt_chan_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .wr_en    (wr_acc & sel),
        .clr_stat (rd_acc & sel & (grp == G_STAT)),
        .grp      (grp),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .rd_word  (words[c]),
        .irq      (irq[c])
      );
    end
  endgenerate

  tt_read_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) i_rmux (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_acc   (rd_acc),
    .chan     (chan),
    .words    (words),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/tt_regbank_checker.sv
module tt_regbank_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CH-1:0] irq
);
  logic armed;
  int   idx;
  logic rd_acc, wr_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign idx    = int'(bus_addr >> 2);
  assign rd_acc = bus_valid & ~bus_write;
  assign wr_acc = bus_valid & bus_write;

  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rd_acc |=> rd_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !rd_acc |=> (!rd_valid && rd_data == '0));
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_acc && idx >= 10 * NUM_CH) |=> (rd_data == '0));
  p_count_zext_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_acc && idx >= 2 * NUM_CH && idx < 3 * NUM_CH) |=> (rd_data[DATA_W-1:CNT_W] == '0));
  p_ctrl_bit4_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_acc && idx >= NUM_CH && idx < 2 * NUM_CH) |=> (rd_data[4] == 1'b0 && rd_data[DATA_W-1:6] == '0));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
      p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (wr_acc && idx == 8 * NUM_CH + c && bus_wdata[5:0] == 6'd0) |=> !irq[c]);
    end
  endgenerate
endmodule

bind tri_timer_regbank tt_regbank_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_CH(NUM_CH)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/test_tri_timer_regbank.sv
`timescale 1ns/1ps
module test_tri_timer_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string tag_force = "";

  always #10 clk = ~clk;

  tri_timer_regbank i_tri_timer_regbank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference
  int m_clk[3], m_ctrl[3], m_intv[3], m_stat[3], m_ien[3], m_evc[3], m_cnt[3];
  int m_match[3][3];
  bit m_rvalid;
  int m_rdata;
  string m_tag;

  function automatic int mval(int g, int c);
    case (g)
      0: return m_clk[c];
      1: return m_ctrl[c];
      2: return m_cnt[c];
      3: return m_intv[c];
      4, 5, 6: return m_match[g-4][c];
      7: return m_stat[c];
      8: return m_ien[c];
      9: return m_evc[c];
      default: return 0;
    endcase
  endfunction

  function automatic string gtag(int g);
    case (g)
      0, 3, 8, 9: return "R3";
      1: return "R4";
      2: return "R5";
      4, 5, 6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_clk[c] = 0; m_ctrl[c] = 'h21; m_intv[c] = 0; m_stat[c] = 0;
        m_ien[c] = 0; m_evc[c] = 0; m_cnt[c] = 0;
        for (int k = 0; k < 3; k++) m_match[k][c] = 0;
      end
      m_rvalid = 0; m_rdata = 0; m_tag = "R1";
    end else begin
      int idx, ch, g, d;
      bit rd, wr;
      idx = int'(bus_addr) >> 2; ch = idx % 3; g = idx / 3; d = int'(bus_wdata);
      rd = bus_valid && !bus_write; wr = bus_valid && bus_write;
      m_rvalid = rd;
      m_rdata  = rd ? mval(g, ch) : 0;
      m_tag    = (tag_force != "") ? tag_force : gtag(g);
      for (int c = 0; c < 3; c++) begin
        int ev, nc;
        ev = 0; nc = m_cnt[c];
        if ((m_ctrl[c] & 1) == 0) begin
          if ((m_ctrl[c] & 2) != 0 && m_cnt[c] == m_intv[c]) begin nc = 0; ev |= 1; end
          else if (m_cnt[c] == 'hFFFF) begin nc = 0; ev |= 16; end
          else nc = m_cnt[c] + 1;
          if ((m_ctrl[c] & 8) != 0)
            for (int k = 0; k < 3; k++) if (m_cnt[c] == m_match[k][c]) ev |= (2 << k);
        end
        if (wr && ch == c) begin
          case (g)
            0: m_clk[c] = d & 'h3F;
            1: begin m_ctrl[c] = d & 'h2F; if ((d & 'h10) != 0) nc = 0; end
            3: m_intv[c] = d & 'hFFFF;
            4, 5, 6: m_match[g-4][c] = d & 'hFFFF;
            8: m_ien[c] = d & 'h3F;
            9: m_evc[c] = d & 'h7;
            default: ;
          endcase
        end
        if (rd && ch == c && g == 7) m_stat[c] = 0;
        m_stat[c] |= ev;
        m_cnt[c] = nc;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_valid == m_rvalid, "R10", int'(rd_valid), int'(m_rvalid));
      if (m_rvalid) check(rd_data == m_rdata, m_tag, int'(rd_data), m_rdata);
      for (int c = 0; c < 3; c++)
        check(irq[c] == ((m_stat[c] & m_ien[c]) != 0), "R9", int'(irq[c]),
              int'((m_stat[c] & m_ien[c]) != 0));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
      finish_run();
    end
  end

  task automatic acc(bit w, int a, int d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a[7:0]; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  function automatic int ad(int g, int c);
    return g * 12 + c * 4;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state of every group on every channel
    tag_force = "R1";
    for (int g = 0; g < 11; g++)
      for (int c = 0; c < 3; c++) acc(0, ad(g, c), 0);
    // R2: interleave, distinct values per channel, byte offsets ignored
    tag_force = "R2";
    for (int c = 0; c < 3; c++) acc(1, ad(3, c) + c, 'h1110 * (c + 1));
    for (int c = 0; c < 3; c++) acc(0, ad(3, c) + 3 - c, 0);
    for (int c = 0; c < 3; c++) acc(0, ad(4, c), 0);
    tag_force = "";
    // R3/R6 write masks with all ones
    for (int g = 0; g < 11; g++) if (g != 1) acc(1, ad(g, 2), 32'hFFFF_FFFF);
    for (int g = 0; g < 11; g++) acc(0, ad(g, 2), 0);
    // R4 counter control mask, channel 2 stays halted
    acc(1, ad(1, 2), 'hFFFF_FFFD);
    acc(0, ad(1, 2), 0);
    acc(1, ad(1, 2), 'h21);
    // R8 unmapped access
    acc(1, 'h84, 'hFFFF); acc(0, 'h84, 0); acc(0, 'hFC, 0);
    acc(1, ad(10, 0), 'hFFFF); acc(0, ad(10, 0), 0);
    // R5/R6/R7/R9: channel 0 interval mode with match, reads collide with events
    acc(1, ad(3, 0), 2);
    acc(1, ad(4, 0), 1);
    acc(1, ad(5, 0), 2);
    acc(1, ad(6, 0), 7);
    acc(1, ad(8, 0), 'h3F);
    acc(1, ad(1, 0), 'h1A);
    for (int i = 0; i < 40; i++) begin
      acc(0, ad(7, 0), 0);
      if (i % 5 == 0) acc(0, ad(2, 0), 0);
      if (i % 7 == 0) acc(1, ad(7, 0), 0);
    end
    // R9 interrupt follows enable
    acc(1, ad(8, 0), 0);
    acc(1, ad(8, 0), 2);
    repeat (3) @(negedge clk);
    // R4 count reset while running
    acc(1, ad(1, 0), 'h12);
    acc(0, ad(2, 0), 0);
    acc(1, ad(1, 0), 'h01);
    acc(0, ad(7, 0), 0);
    // R5 free-run overflow on channel 1
    acc(1, ad(8, 1), 'h10);
    acc(1, ad(1, 1), 'h10);
    repeat (65540) @(negedge clk);
    acc(0, ad(2, 1), 0);
    acc(0, ad(7, 1), 0);
    acc(0, ad(7, 1), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule